// File: doc/BRIEF.md
# Per-Hart Wired Interrupt Selector

This block sits between the interrupt source sensing logic and the harts of one interrupt domain that uses wired delivery. Every source carries a target record naming the hart it is routed to and its priority. For each hart the block picks, out of the sources that are enabled, pending and routed to that hart, the one with the smallest priority value. When a hart's delivery is switched on, it drives that hart's external interrupt line.

Software sees a small register window. Each source has a target word. Each hart has a 32-byte control group: a delivery switch, a force bit, a priority threshold, a read-only top word and a claim word. Reading the claim word has side effects. It takes the reported source out of the pending state. A level-sensitive source whose input is still active is put back into the pending state.

The sensing logic delivers single-cycle pending pulses and the per-source enable, level mode and raw input. The pending bits themselves live in this block, so that a claim can clear them.

Top module: `irqsel_direct`

## Requirements
- R1: After reset every hart line is low, every top word reads zero, delivery, force and threshold read zero, and every target word reads hart 0 with priority 1.
- R2: A source is a candidate for hart h only when its enable input is high, its pending bit is set and its target hart field (target bits 31:18) equals h. A source routed to any other hart is never reported for h.
- R3: Among the candidates of a hart, the smallest priority value is reported.
- R4: When candidates share the smallest priority, the lowest source number is reported.
- R5: A nonzero threshold (hart offset 0x08) removes candidates whose priority is greater than or equal to it, and zero removes none. Threshold writes keep only the low PRIO_W bits.
- R6: The top word (hart offset 0x18) holds the source number in bits 25:16 and its priority in bits 7:0. It is all zero when the hart has no candidate.
- R7: A hart line is high exactly when the domain enable input is high, that hart's delivery bit is 1, and either its force bit is 1 or it has a candidate.
- R8: A read of the claim word (hart offset 0x1C) returns the top word and clears the reported source's pending bit, once per read strobe.
- R9: At a claim, a source in level-high mode whose input is 1, or in level-low mode whose input is 0, stays pending.
- R10: A claim read on a hart with no candidate returns zero and clears that hart's force bit.
- R11: A target write (source s at byte address 4*s, s from 1 to N_SRC) stores the hart field and the low PRIO_W bits of the priority (bits 7:0). A resulting priority of 0 is stored as 1.
- R12: The delivery (offset 0x00) and force (offset 0x04) registers keep only bit 0 of the written data.
- R13: Read data appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| domain_ie_i | input | 1 | Domain-wide interrupt enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe, one cycle per read |
| bus_addr_i | input | 16 | Byte address; targets below 0x4000, hart h groups at 0x4000 + 32*h |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| src_en_i | input | N_SRC | Per-source enable, bit k-1 is source k |
| src_pend_set_i | input | N_SRC | Per-source pending set pulse from sensing logic |
| src_lvl_hi_i | input | N_SRC | Source is in level-high mode |
| src_lvl_lo_i | input | N_SRC | Source is in level-low mode |
| src_level_i | input | N_SRC | Raw source input level |
| hart_irq_o | output | N_HART | External interrupt line per hart |

## Verification
The bench looks hardest at the ordering rules. It builds ties and near misses on priority. A selector that compared with less-or-equal would report source 5 in place of source 3 or 1. It also sets the threshold equal to the candidates' priority, where an off-by-one would still let them through, and writes a threshold wider than the field to expose missing masking. Claims are checked on edge, level-high and level-low sources, both with the input still active and after it has dropped. A missing re-pend shows up as an empty top word, and a double clear or a clear of the wrong source shows up as a wrong next winner. The empty claim checks that force is cleared and the line falls. The target writes check that priority zero turns into one and not into a source that wins everything.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int unsigned HART_FIELD_W = 14;
  localparam int unsigned TGT_HART_LSB = 18;
  localparam int unsigned TOP_ID_LSB   = 16;
  localparam logic [1:0]  REGION_TGT   = 2'b00;
  localparam logic [1:0]  REGION_HART  = 2'b01;
  localparam logic [4:0]  OFS_DELIV    = 5'h00;
  localparam logic [4:0]  OFS_FORCE    = 5'h04;
  localparam logic [4:0]  OFS_THR      = 5'h08;
  localparam logic [4:0]  OFS_TOP      = 5'h18;
  localparam logic [4:0]  OFS_CLAIM    = 5'h1C;
endpackage

// File: rtl/irqsel_src_bank.sv
module irqsel_src_bank #(
  parameter int unsigned N_SRC  = 7,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned HF_W   = 14
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_SRC-1:0]                  tgt_we_i,
  input  logic [HF_W-1:0]                   wr_hart_i,
  input  logic [PRIO_W-1:0]                 wr_prio_i,
  input  logic [N_SRC-1:0]                  pend_set_i,
  input  logic [N_SRC-1:0]                  claim_clr_i,
  input  logic [N_SRC-1:0]                  lvl_hi_i,
  input  logic [N_SRC-1:0]                  lvl_lo_i,
  input  logic [N_SRC-1:0]                  level_i,
  output logic [N_SRC-1:0]                  pend_o,
  output logic [N_SRC-1:0][HF_W-1:0]        tgt_hart_o,
  output logic [N_SRC-1:0][PRIO_W-1:0]      tgt_prio_o
);
  logic [N_SRC-1:0]   pend_q, pend_d, relevel;
  logic [PRIO_W-1:0]  prio_fix;
  logic               pend_en;

  // zero priority is not representable in wired mode: floor at one
  always_comb begin
    prio_fix = (wr_prio_i == '0) ? PRIO_W'(1) : wr_prio_i;
    relevel  = (lvl_hi_i & level_i) | (lvl_lo_i & ~level_i);
    pend_d   = pend_set_i | (claim_clr_i & relevel) | (~claim_clr_i & pend_q);
    pend_en  = |(pend_set_i | claim_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_tgt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tgt_hart_o[s] <= '0;
        tgt_prio_o[s] <= PRIO_W'(1);
      end else if (tgt_we_i[s]) begin
        tgt_hart_o[s] <= wr_hart_i;
        tgt_prio_o[s] <= prio_fix;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick #(
  parameter int unsigned N_SRC   = 7,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned HF_W    = 14,
  parameter int unsigned HART_ID = 0,
  localparam int unsigned ID_W   = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0]             elig_i,
  input  logic [N_SRC-1:0][HF_W-1:0]   tgt_hart_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] tgt_prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic                         found_o,
  output logic [ID_W-1:0]              id_o,
  output logic [PRIO_W-1:0]            prio_o
);
  logic [N_SRC-1:0] cand;

  always_comb begin
    for (int s = 0; s < N_SRC; s++) begin
      cand[s] = elig_i[s] && (tgt_hart_i[s] == HF_W'(HART_ID)) &&
                ((thr_i == '0) || (tgt_prio_i[s] < thr_i));
    end
  end

  // scan in ascending source order; strict less-than keeps the lower number on ties
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (cand[s] && (!found_o || (tgt_prio_i[s] < prio_o))) begin
        found_o = 1'b1;
        id_o    = ID_W'(s + 1);
        prio_o  = tgt_prio_i[s];
      end
    end
  end
endmodule

// File: rtl/irqsel_hart_regs.sv
module irqsel_hart_regs
  import irqsel_pkg::*;
#(
  parameter int unsigned N_HART = 2,
  parameter int unsigned PRIO_W = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [8:0]                        hart_sel_i,
  input  logic [4:0]                        ofs_i,
  input  logic                              wbit_i,
  input  logic [PRIO_W-1:0]                 wthr_i,
  input  logic [N_HART-1:0]                 frc_clr_i,
  output logic [N_HART-1:0]                 deliv_o,
  output logic [N_HART-1:0]                 force_o,
  output logic [N_HART-1:0][PRIO_W-1:0]     thr_o
);
  logic [N_HART-1:0]             deliv_q, deliv_d, frc_q, frc_d;
  logic [N_HART-1:0][PRIO_W-1:0] thr_q, thr_d;
  logic                          upd;

  always_comb begin
    deliv_d = deliv_q;
    frc_d   = frc_q;
    thr_d   = thr_q;
    for (int h = 0; h < N_HART; h++) begin
      if (wr_i && (hart_sel_i == 9'(h))) begin
        case (ofs_i)
          OFS_DELIV: deliv_d[h] = wbit_i;
          OFS_FORCE: frc_d[h]   = wbit_i;
          OFS_THR:   thr_d[h]   = wthr_i;
          default: ;
        endcase
      end
      if (frc_clr_i[h]) frc_d[h] = 1'b0;
    end
    upd = wr_i | (|frc_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deliv_q <= '0;
      frc_q   <= '0;
      thr_q   <= '0;
    end else if (upd) begin
      deliv_q <= deliv_d;
      frc_q   <= frc_d;
      thr_q   <= thr_d;
    end
  end

  assign deliv_o = deliv_q;
  assign force_o = frc_q;
  assign thr_o   = thr_q;
endmodule

// File: rtl/irqsel_direct.sv
module irqsel_direct
  import irqsel_pkg::*;
#(
  parameter int unsigned N_HART = 2,
  parameter int unsigned N_SRC  = 7,
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              domain_ie_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [15:0]       bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [N_SRC-1:0]  src_en_i,
  input  logic [N_SRC-1:0]  src_pend_set_i,
  input  logic [N_SRC-1:0]  src_lvl_hi_i,
  input  logic [N_SRC-1:0]  src_lvl_lo_i,
  input  logic [N_SRC-1:0]  src_level_i,
  output logic [N_HART-1:0] hart_irq_o
);
  localparam int unsigned ID_W = $clog2(N_SRC + 1);
  localparam int unsigned HF_W = HART_FIELD_W;

  logic [1:0]  rst_sync_q;
  logic        rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic        hart_region, tgt_region, claim_hit;
  logic [8:0]  hart_sel;
  logic [4:0]  ofs;
  logic [11:0] src_num;

  assign hart_region = (bus_addr_i[15:14] == REGION_HART);
  assign tgt_region  = (bus_addr_i[15:14] == REGION_TGT) && (bus_addr_i[1:0] == 2'b00);
  assign hart_sel    = bus_addr_i[13:5];
  assign ofs         = bus_addr_i[4:0];
  assign src_num     = bus_addr_i[13:2];
  assign claim_hit   = bus_rd_i && hart_region && (ofs == OFS_CLAIM);

  logic [N_SRC-1:0]              pend, tgt_we, claim_clr;
  logic [N_SRC-1:0][HF_W-1:0]    tgt_hart;
  logic [N_SRC-1:0][PRIO_W-1:0]  tgt_prio;
  logic [N_HART-1:0]             deliv, frc, frc_clr, found;
  logic [N_HART-1:0][PRIO_W-1:0] thr, top_prio;
  logic [N_HART-1:0][ID_W-1:0]   top_id;
  logic [N_HART-1:0][31:0]       top_word;

  always_comb begin
    for (int s = 0; s < N_SRC; s++) begin
      tgt_we[s]    = bus_wr_i && tgt_region && (src_num == 12'(s + 1));
      claim_clr[s] = 1'b0;
      for (int h = 0; h < N_HART; h++) begin
        if (claim_hit && (hart_sel == 9'(h)) && found[h] && (top_id[h] == ID_W'(s + 1)))
          claim_clr[s] = 1'b1;
      end
    end
    for (int h = 0; h < N_HART; h++) begin
      frc_clr[h] = claim_hit && (hart_sel == 9'(h)) && !found[h];
    end
  end

  irqsel_src_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .HF_W(HF_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .tgt_we_i    (tgt_we),
    .wr_hart_i   (bus_wdata_i[TGT_HART_LSB +: HF_W]),
    .wr_prio_i   (bus_wdata_i[PRIO_W-1:0]),
    .pend_set_i  (src_pend_set_i),
    .claim_clr_i (claim_clr),
    .lvl_hi_i    (src_lvl_hi_i),
    .lvl_lo_i    (src_lvl_lo_i),
    .level_i     (src_level_i),
    .pend_o      (pend),
    .tgt_hart_o  (tgt_hart),
    .tgt_prio_o  (tgt_prio)
  );

  irqsel_hart_regs #(.N_HART(N_HART), .PRIO_W(PRIO_W)) u_hregs (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .wr_i       (bus_wr_i && hart_region),
    .hart_sel_i (hart_sel),
    .ofs_i      (ofs),
    .wbit_i     (bus_wdata_i[0]),
    .wthr_i     (bus_wdata_i[PRIO_W-1:0]),
    .frc_clr_i  (frc_clr),
    .deliv_o    (deliv),
    .force_o    (frc),
    .thr_o      (thr)
  );

  for (genvar h = 0; h < N_HART; h++) begin : g_pick
    irqsel_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .HF_W(HF_W), .HART_ID(h)) u_pick (
      .elig_i     (src_en_i & pend),
      .tgt_hart_i (tgt_hart),
      .tgt_prio_i (tgt_prio),
      .thr_i      (thr[h]),
      .found_o    (found[h]),
      .id_o       (top_id[h]),
      .prio_o     (top_prio[h])
    );
    assign top_word[h] = found[h] ? ((32'(top_id[h]) << TOP_ID_LSB) | 32'(top_prio[h])) : 32'd0;
  end

  assign hart_irq_o = {N_HART{domain_ie_i}} & deliv & (frc | found);

  logic [31:0] rd_val, rdata_q;

  always_comb begin
    rd_val = '0;
    if (hart_region) begin
      for (int h = 0; h < N_HART; h++) begin
        if (hart_sel == 9'(h)) begin
          case (ofs)
            OFS_DELIV:         rd_val = {31'd0, deliv[h]};
            OFS_FORCE:         rd_val = {31'd0, frc[h]};
            OFS_THR:           rd_val = 32'(thr[h]);
            OFS_TOP, OFS_CLAIM: rd_val = top_word[h];
            default: ;
          endcase
        end
      end
    end else if (tgt_region) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (src_num == 12'(s + 1))
          rd_val = (32'(tgt_hart[s]) << TGT_HART_LSB) | 32'(tgt_prio[s]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)   rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/irqsel_direct_chk.sv
module irqsel_direct_chk #(
  parameter int unsigned N_HART = 2,
  parameter int unsigned N_SRC  = 7,
  parameter int unsigned PRIO_W = 3
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              domain_ie_i,
  input logic                              bus_rd_i,
  input logic [31:0]                       bus_rdata_o,
  input logic [N_HART-1:0]                 hart_irq_o,
  input logic [N_HART-1:0]                 deliv,
  input logic [N_SRC-1:0]                  claim_clr,
  input logic [N_SRC-1:0][PRIO_W-1:0]      tgt_prio,
  input logic [N_HART-1:0]                 found,
  input logic [N_HART-1:0][PRIO_W-1:0]     top_prio,
  input logic [N_HART-1:0][PRIO_W-1:0]     thr
);
  // R7: a raised line implies domain enable and that hart's delivery bit
  p_line_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hart_irq_o != '0) |-> (domain_ie_i && ((hart_irq_o & ~deliv) == '0)));

  // R8: one claim strobe clears at most one source
  p_single_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_clr));

  // R8: nothing is cleared without a read strobe
  p_clear_needs_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_clr != '0) |-> bus_rd_i);

  // R13: read data only moves after a read strobe
  p_rdata_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));

  for (genvar h = 0; h < N_HART; h++) begin : g_h
    // R5: a reported priority always sits below a nonzero threshold
    p_below_thr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (found[h] && (thr[h] != '0)) |-> (top_prio[h] < thr[h]));
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_s
    // R11: stored priorities never hold zero
    p_prio_floor_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_prio[s] != '0);
  end
endmodule

bind irqsel_direct irqsel_direct_chk #(.N_HART(N_HART), .N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .domain_ie_i (domain_ie_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .hart_irq_o  (hart_irq_o),
  .deliv       (deliv),
  .claim_clr   (claim_clr),
  .tgt_prio    (tgt_prio),
  .found       (found),
  .top_prio    (top_prio),
  .thr         (thr)
);

// File: tb/irqsel_direct_bench.sv
module irqsel_direct_bench;
  localparam int NH = 2;
  localparam int NS = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ie;
  logic          wr, rd;
  logic [15:0]   addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NS-1:0] en, pset, lhi, llo, lvl;
  logic [NH-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irqsel_direct #(.N_HART(NH), .N_SRC(NS), .PRIO_W(3)) u_irqsel_direct (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .domain_ie_i    (ie),
    .bus_wr_i       (wr),
    .bus_rd_i       (rd),
    .bus_addr_i     (addr),
    .bus_wdata_i    (wdata),
    .bus_rdata_o    (rdata),
    .src_en_i       (en),
    .src_pend_set_i (pset),
    .src_lvl_hi_i   (lhi),
    .src_lvl_lo_i   (llo),
    .src_level_i    (lvl),
    .hart_irq_o     (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    @(negedge clk); pset = m;
    @(negedge clk); pset = '0;
  endtask

  function automatic logic [15:0] hreg(input int h, input logic [4:0] o);
    return 16'h4000 + 16'(h * 32) + 16'(o);
  endfunction

  function automatic logic [31:0] topw(input int id, input int p);
    return (32'(id) << 16) | 32'(p);
  endfunction

  logic [31:0] v;

  task automatic t_reset();
    check("R1 lines", 32'(irq), 32'd0);
    rd_reg(hreg(0, 5'h18), v); check("R1 top", v, 0);
    rd_reg(hreg(1, 5'h04), v); check("R1 force", v, 0);
    rd_reg(16'h000C, v);       check("R1 target", v, 32'h1);
  endtask

  task automatic t_route();
    wr_reg(16'h0008, (32'd1 << 18) | 32'd4);
    en[1] = 1'b1;
    pulse(7'b0000010);
    check("R7 line hart1", 32'(irq), 32'b10);
    rd_reg(hreg(1, 5'h18), v); check("R6 top format", v, 32'h0002_0004);
    rd_reg(hreg(0, 5'h18), v); check("R2 other hart", v, 0);
    @(negedge clk); en[1] = 1'b0;
    @(negedge clk); check("R2 disabled line", 32'(irq), 0);
    rd_reg(hreg(1, 5'h18), v); check("R2 disabled top", v, 0);
  endtask

  task automatic t_prio();
    wr_reg(16'h0004, 32'd5);
    wr_reg(16'h000C, 32'd2);
    wr_reg(16'h0014, 32'd6);
    en = en | 7'b0010101;
    pulse(7'b0010101);
    rd_reg(hreg(0, 5'h18), v); check("R3 min prio", v, topw(3, 2));
    wr_reg(16'h0014, 32'd2);
    rd_reg(hreg(0, 5'h18), v); check("R4 tie low id", v, topw(3, 2));
    rd_reg(hreg(0, 5'h1C), v); check("R8 claim value", v, topw(3, 2));
    rd_reg(hreg(0, 5'h18), v); check("R8 cleared once", v, topw(5, 2));
    wr_reg(16'h0004, 32'd2);
    rd_reg(hreg(0, 5'h18), v); check("R4 tie src1", v, topw(1, 2));
  endtask

  task automatic t_thr();
    wr_reg(hreg(0, 5'h08), 32'd2);
    rd_reg(hreg(0, 5'h18), v); check("R5 equal excluded", v, 0);
    check("R5 line low", 32'(irq[0]), 0);
    wr_reg(hreg(0, 5'h08), 32'd3);
    rd_reg(hreg(0, 5'h18), v); check("R5 below passes", v, topw(1, 2));
    wr_reg(hreg(0, 5'h08), 32'hF9);
    rd_reg(hreg(0, 5'h08), v); check("R5 masked thr", v, 32'd1);
    rd_reg(hreg(0, 5'h18), v); check("R5 thr one", v, 0);
    wr_reg(hreg(0, 5'h08), 32'd0);
    rd_reg(hreg(0, 5'h18), v); check("R5 zero thr", v, topw(1, 2));
  endtask

  task automatic t_force();
    wr_reg(hreg(1, 5'h04), 32'hFFFF_FFFF);
    rd_reg(hreg(1, 5'h04), v); check("R12 force bit0", v, 32'd1);
    check("R7 forced line", 32'(irq[1]), 1);
    wr_reg(hreg(1, 5'h00), 32'hFFFF_FFFE);
    rd_reg(hreg(1, 5'h00), v); check("R12 deliv bit0", v, 0);
    check("R7 no delivery", 32'(irq[1]), 0);
    wr_reg(hreg(1, 5'h00), 32'd1);
    check("R7 delivery on", 32'(irq[1]), 1);
    @(negedge clk); ie = 1'b0;
    @(negedge clk); check("R7 domain off", 32'(irq), 0);
    ie = 1'b1;
    rd_reg(hreg(1, 5'h1C), v); check("R10 empty claim", v, 0);
    rd_reg(hreg(1, 5'h04), v); check("R10 force cleared", v, 0);
    check("R10 line low", 32'(irq[1]), 0);
  endtask

  task automatic t_level();
    wr_reg(16'h0018, (32'd1 << 18) | 32'd3);
    lhi[5] = 1'b1; lvl[5] = 1'b1; en[5] = 1'b1;
    pulse(7'b0100000);
    rd_reg(hreg(1, 5'h1C), v); check("R9 hi claim", v, topw(6, 3));
    rd_reg(hreg(1, 5'h18), v); check("R9 hi re-pend", v, topw(6, 3));
    lvl[5] = 1'b0;
    rd_reg(hreg(1, 5'h1C), v); check("R9 hi claim2", v, topw(6, 3));
    rd_reg(hreg(1, 5'h18), v); check("R9 hi dropped", v, 0);
    wr_reg(16'h001C, (32'd1 << 18) | 32'd3);
    llo[6] = 1'b1; lvl[6] = 1'b0; en[6] = 1'b1;
    pulse(7'b1000000);
    rd_reg(hreg(1, 5'h1C), v); check("R9 lo claim", v, topw(7, 3));
    rd_reg(hreg(1, 5'h18), v); check("R9 lo re-pend", v, topw(7, 3));
    lvl[6] = 1'b1;
    rd_reg(hreg(1, 5'h1C), v); check("R9 lo claim2", v, topw(7, 3));
    rd_reg(hreg(1, 5'h18), v); check("R9 lo dropped", v, 0);
  endtask

  task automatic t_target();
    wr_reg(16'h0010, 32'd1 << 18);
    rd_reg(16'h0010, v); check("R11 zero prio", v, 32'h0004_0001);
    wr_reg(16'h0010, 32'h0A);
    rd_reg(16'h0010, v); check("R11 masked prio", v, 32'd2);
    wr_reg(16'h0010, 32'h08);
    rd_reg(16'h0010, v); check("R11 masked to zero", v, 32'd1);
  endtask

  task automatic t_rdlat();
    rd_reg(hreg(0, 5'h00), v); check("R13 setup", v, 32'd1);
    @(negedge clk); addr = hreg(1, 5'h18); rd = 1'b1;
    #1 check("R13 before edge", rdata, 32'd1);
    @(negedge clk); rd = 1'b0;
    check("R13 after edge", rdata, 0);
    @(negedge clk); check("R13 held", rdata, 0);
  endtask

  initial begin
    rst_n = 1'b0; ie = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    en = '0; pset = '0; lhi = '0; llo = '0; lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    ie = 1'b1;
    wr_reg(hreg(0, 5'h00), 32'd1);
    wr_reg(hreg(1, 5'h00), 32'd1);
    t_route();
    t_prio();
    t_thr();
    t_force();
    t_level();
    t_target();
    t_rdlat();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule